// File: doc/BRIEF.md
# Supply Margining Trim Controller

This block closes a digital regulation loop around two supply converters. Each converter has a trim input. The block compares a digitized sense voltage for each channel with a stored setpoint and moves a trim code one step per sampling period, so that the converter output settles on that setpoint. Each channel stores three setpoints: nominal, margin-high and margin-low. A 2-bit command selects one of them, which lets a test host push a rail up or down and then return it to its nominal level.

The loop runs only while the active-control enable is high and the start input is at its programmed active level. At any other time the trim output is released (output enable low) and the trim code follows a seed value that reports the converter's present trim level. The loop therefore picks up from that level without a jump. Every channel can use normal or inverse trim polarity. A fast mode takes large steps while the error is large. A channel reports ready once its sense value has stayed within a deadband for two sampling ticks in a row. The ready output combines both channels and has a programmable polarity.

Top module: `margin_trim_ctrl`

## Requirements
- R1: The trim code of a running channel changes only on a sampling tick, one tick every TICK_DIV clocks, and by at most one step per tick.
- R2: Command encoding per channel: 2'b00 nominal, 2'b01 margin-high, 2'b10 margin-low, 2'b11 nominal. The command is written through that channel's cmd_we_i bit.
- R3: A command written while ctl_en_i is low is discarded, and the previously selected setpoint stays in force.
- R4: With normal polarity (trim_inv_i bit 0) the code rises by a step when the sample is below the target and falls when it is above. With inverse polarity (bit 1) the direction is reversed.
- R5: The step is FAST_STEP (8) when fast_en_i is high and the absolute error exceeds FAST_STEP. In every other case the step is 1.
- R6: The trim code saturates at 0 and at 2^TRIM_W-1 and never wraps.
- R7: A channel's ready flag rises on a tick when the absolute error is at most deadband_i on that tick and on the previous one. An accepted command clears the flag on the next clock. So does a stopped loop.
- R8: ready_o is the AND of both channel ready flags, driven as-is when ready_pol_i=1 and inverted when ready_pol_i=0.
- R9: The loop runs only while ctl_en_i is high and start_i equals start_pol_i. While the loop is stopped, trim_oe_o is low, the ready flags are low and the trim code follows trim_seed_i.
- R10: Setpoints are 16-bit values loaded by byte. reg_addr_i = {channel, select[1:0], upper}. Select is 00 nominal, 01 high, 10 low. upper=1 loads bits 15:8 and upper=0 loads bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_en_i | input | 1 | Active output control enable |
| start_i | input | 1 | Start input |
| start_pol_i | input | 1 | Active level of start_i |
| ready_pol_i | input | 1 | 1: ready_o active high, 0: active low |
| fast_en_i | input | 1 | Fast-convergence enable |
| trim_inv_i | input | NCH | Per-channel inverse trim polarity |
| deadband_i | input | DB_W | Ready deadband in LSB |
| reg_we_i | input | 1 | Setpoint byte write strobe |
| reg_addr_i | input | ADDR_W | Setpoint byte address |
| reg_wdata_i | input | 8 | Setpoint byte data |
| cmd_we_i | input | NCH | Per-channel command write strobe |
| cmd_i | input | 2*NCH | Per-channel margin command |
| sample_i | input | NCH*SP_W | Digitized sense voltage per channel |
| trim_seed_i | input | NCH*TRIM_W | Present trim level, loaded while stopped |
| trim_code_o | output | NCH*TRIM_W | Trim code per channel |
| trim_oe_o | output | NCH | Trim drive enable (0 = high impedance) |
| ch_ready_o | output | NCH | Per-channel ready flag |
| ready_o | output | 1 | Combined ready, polarity applied |

## Verification
The assertions assume that sample_i is stable or changes slowly relative to the trim code. They also assume that command strobes do not repeat every clock, because a strobe repeated every clock would keep ready cleared forever. The stimulus keeps every input change on the falling clock edge. For the step and direction scenarios it holds the samples at fixed values. For the convergence scenarios it derives the samples from the trim code through a linear plant model, one rising and one falling. This keeps the loop inside the conditions the properties rely on.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int SETPT_W = 16;
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {
    CMD_NOM   = 2'b00,
    CMD_HIGH  = 2'b01,
    CMD_LOW   = 2'b10,
    CMD_NOM_B = 2'b11
  } mtc_cmd_e;

  typedef enum logic [1:0] {
    SEL_NOM  = 2'b00,
    SEL_HIGH = 2'b01,
    SEL_LOW  = 2'b10
  } mtc_sel_e;
endpackage

// File: rtl/mtc_tick_gen.sv
module mtc_tick_gen #(
  parameter int TICK_DIV = 212500
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || TICK_DIV == 1)); // R1
endmodule

// File: rtl/mtc_setpt.sv
module mtc_setpt
  import mtc_pkg::*;
#(
  parameter int CH     = 0,
  parameter int CH_W   = 1,
  parameter int ADDR_W = 4,
  parameter int SP_W   = SETPT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  input  logic              cmd_we_i,
  input  logic [1:0]        cmd_i,
  output logic [SP_W-1:0]   target_o,
  output logic              cmd_new_o
);
  logic [SP_W-1:0] sp_nom_q, sp_hi_q, sp_lo_q;
  mtc_cmd_e        cmd_q;
  logic            hit;

  assign hit       = reg_we_i && (reg_addr_i[ADDR_W-1:3] == CH_W'(CH));
  assign cmd_new_o = cmd_we_i && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_nom_q <= '0;
      sp_hi_q  <= '0;
      sp_lo_q  <= '0;
    end else if (hit) begin
      case (mtc_sel_e'(reg_addr_i[2:1]))
        SEL_NOM: begin
          if (reg_addr_i[0]) sp_nom_q[SP_W-1:BYTE_W] <= reg_wdata_i[SP_W-BYTE_W-1:0];
          else               sp_nom_q[BYTE_W-1:0]    <= reg_wdata_i;
        end
        SEL_HIGH: begin
          if (reg_addr_i[0]) sp_hi_q[SP_W-1:BYTE_W] <= reg_wdata_i[SP_W-BYTE_W-1:0];
          else               sp_hi_q[BYTE_W-1:0]    <= reg_wdata_i;
        end
        SEL_LOW: begin
          if (reg_addr_i[0]) sp_lo_q[SP_W-1:BYTE_W] <= reg_wdata_i[SP_W-BYTE_W-1:0];
          else               sp_lo_q[BYTE_W-1:0]    <= reg_wdata_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cmd_q <= CMD_NOM;
    else if (cmd_new_o) cmd_q <= mtc_cmd_e'(cmd_i);
  end

  always_comb begin
    case (cmd_q)
      CMD_HIGH: target_o = sp_hi_q;
      CMD_LOW:  target_o = sp_lo_q;
      default:  target_o = sp_nom_q;
    endcase
  end

  AST_CMD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !en_i) |=> $stable(cmd_q)); // R3
endmodule

// File: rtl/mtc_trim_loop.sv
module mtc_trim_loop #(
  parameter int SP_W      = 16,
  parameter int TRIM_W    = 10,
  parameter int DB_W      = 4,
  parameter int FAST_STEP = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              fast_en_i,
  input  logic              inv_i,
  input  logic [DB_W-1:0]   deadband_i,
  input  logic              cmd_new_i,
  input  logic [SP_W-1:0]   target_i,
  input  logic [SP_W-1:0]   sample_i,
  input  logic [TRIM_W-1:0] seed_i,
  output logic [TRIM_W-1:0] code_o,
  output logic              oe_o,
  output logic              ready_o
);
  localparam int DW = SP_W + 1;
  localparam logic [TRIM_W-1:0] CODE_MAX = '1;

  logic signed [DW-1:0] diff;
  logic [DW-1:0]        mag;
  logic [TRIM_W-1:0]    step, nxt, code_q;
  logic                 up, in_band, seen_q, ready_q, oe_q;

  always_comb begin
    diff    = $signed({1'b0, target_i}) - $signed({1'b0, sample_i});
    mag     = diff[DW-1] ? DW'(-diff) : DW'(diff);
    in_band = mag <= DW'(deadband_i);
    step    = (fast_en_i && mag > DW'(FAST_STEP)) ? TRIM_W'(FAST_STEP) : TRIM_W'(1);
    up      = (!diff[DW-1]) ^ inv_i;
    if (up) nxt = (code_q > CODE_MAX - step) ? CODE_MAX : code_q + step;
    else    nxt = (code_q < step) ? '0 : code_q - step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      oe_q    <= 1'b0;
      seen_q  <= 1'b0;
      ready_q <= 1'b0;
    end else if (!run_i) begin
      code_q  <= seed_i;
      oe_q    <= 1'b0;
      seen_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      oe_q <= 1'b1;
      if (cmd_new_i) begin
        seen_q  <= 1'b0;
        ready_q <= 1'b0;
      end else if (tick_i) begin
        seen_q  <= in_band;
        ready_q <= in_band && seen_q;
        if (!in_band) code_q <= nxt;
      end
    end
  end

  assign code_o  = code_q;
  assign oe_o    = oe_q;
  assign ready_o = ready_q;

  AST_HOLD_OFF_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && oe_q && !tick_i) |=> $stable(code_q)); // R1
  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && oe_q && tick_i && !cmd_new_i) |=>
      (($signed({1'b0, code_q}) - $signed({1'b0, $past(code_q)})) <= ($past(fast_en_i) ? FAST_STEP : 1)) &&
      (($signed({1'b0, $past(code_q)}) - $signed({1'b0, code_q})) <= ($past(fast_en_i) ? FAST_STEP : 1))); // R5
  AST_CMD_CLEARS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_new_i |=> !ready_q); // R7
  AST_READY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_q) |-> $past(tick_i)); // R7
  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!oe_q && !ready_q)); // R9
endmodule

// File: rtl/margin_trim_ctrl.sv
module margin_trim_ctrl
  import mtc_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int SP_W      = SETPT_W,
  parameter int TRIM_W    = 10,
  parameter int DB_W      = 4,
  parameter int FAST_STEP = 8,
  parameter int TICK_DIV  = 212500,
  parameter int CH_W      = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int ADDR_W    = CH_W + 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ctl_en_i,
  input  logic                    start_i,
  input  logic                    start_pol_i,
  input  logic                    ready_pol_i,
  input  logic                    fast_en_i,
  input  logic [NCH-1:0]          trim_inv_i,
  input  logic [DB_W-1:0]         deadband_i,
  input  logic                    reg_we_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [BYTE_W-1:0]       reg_wdata_i,
  input  logic [NCH-1:0]          cmd_we_i,
  input  logic [2*NCH-1:0]        cmd_i,
  input  logic [NCH*SP_W-1:0]     sample_i,
  input  logic [NCH*TRIM_W-1:0]   trim_seed_i,
  output logic [NCH*TRIM_W-1:0]   trim_code_o,
  output logic [NCH-1:0]          trim_oe_o,
  output logic [NCH-1:0]          ch_ready_o,
  output logic                    ready_o
);
  logic tick, run;

  assign run = ctl_en_i && (start_i == start_pol_i);

  mtc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SP_W-1:0] target;
    logic            cmd_new;

    mtc_setpt #(.CH(c), .CH_W(CH_W), .ADDR_W(ADDR_W), .SP_W(SP_W)) u_setpt (
      .clk_i, .rst_ni,
      .en_i       (ctl_en_i),
      .reg_we_i, .reg_addr_i, .reg_wdata_i,
      .cmd_we_i   (cmd_we_i[c]),
      .cmd_i      (cmd_i[2*c +: 2]),
      .target_o   (target),
      .cmd_new_o  (cmd_new)
    );

    mtc_trim_loop #(.SP_W(SP_W), .TRIM_W(TRIM_W), .DB_W(DB_W), .FAST_STEP(FAST_STEP)) u_loop (
      .clk_i, .rst_ni,
      .tick_i     (tick),
      .run_i      (run),
      .fast_en_i,
      .inv_i      (trim_inv_i[c]),
      .deadband_i,
      .cmd_new_i  (cmd_new),
      .target_i   (target),
      .sample_i   (sample_i[c*SP_W +: SP_W]),
      .seed_i     (trim_seed_i[c*TRIM_W +: TRIM_W]),
      .code_o     (trim_code_o[c*TRIM_W +: TRIM_W]),
      .oe_o       (trim_oe_o[c]),
      .ready_o    (ch_ready_o[c])
    );
  end

  assign ready_o = ready_pol_i ? (&ch_ready_o) : ~(&ch_ready_o);

  AST_READY_NEEDS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_ready_o) |-> (|trim_oe_o)); // R9
endmodule

// File: tb/margin_trim_ctrl_tb_top.sv
module margin_trim_ctrl_tb_top;
  localparam int DIV = 8;
  localparam int TW  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ctl_en = 0, start = 0, start_pol = 1, ready_pol = 1, fast_en = 0;
  logic [1:0] inv = 2'b10;
  logic [3:0] db = 4'd2;
  logic reg_we = 0; logic [3:0] reg_addr = '0; logic [7:0] reg_wdata = '0;
  logic [1:0] cmd_we = '0; logic [3:0] cmd = '0;
  logic plant_on = 0;
  logic [15:0] f0 = 16'd1000, f1 = 16'd3000;
  logic [31:0] sample;
  logic [2*TW-1:0] seed = '0, code;
  logic [1:0] oe, chr;
  logic rdy;

  wire [TW-1:0] c0 = code[TW-1:0];
  wire [TW-1:0] c1 = code[2*TW-1:TW];
  always_comb begin
    if (plant_on) sample = {16'(3000 - int'(c1)), 16'(1000 + int'(c0))};
    else          sample = {f1, f0};
  end

  margin_trim_ctrl #(.TICK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctl_en_i(ctl_en), .start_i(start),
    .start_pol_i(start_pol), .ready_pol_i(ready_pol), .fast_en_i(fast_en),
    .trim_inv_i(inv), .deadband_i(db), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .cmd_we_i(cmd_we), .cmd_i(cmd), .sample_i(sample),
    .trim_seed_i(seed), .trim_code_o(code), .trim_oe_o(oe), .ch_ready_o(chr),
    .ready_o(rdy));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_sp(input int ch, input int sel, input int val);
    @(negedge clk); reg_we = 1; reg_addr = 4'({ch[0], sel[1:0], 1'b0}); reg_wdata = val[7:0];
    @(negedge clk); reg_addr = 4'({ch[0], sel[1:0], 1'b1}); reg_wdata = val[15:8];
    @(negedge clk); reg_we = 0;
  endtask

  task automatic issue(input logic [1:0] we, input logic [3:0] v);
    @(negedge clk); cmd_we = we; cmd = v;
    @(negedge clk); cmd_we = '0;
  endtask

  task automatic get_code(input int ch, output int v);
    v = (ch == 0) ? int'(c0) : int'(c1);
  endtask

  // waits for the next code change on a channel, returns delta and cycles waited
  task automatic next_delta(input int ch, output int d, output int gap);
    int old, now;
    get_code(ch, old); d = 0; gap = 0;
    for (int i = 0; i < 4*DIV; i++) begin
      @(negedge clk); gap++;
      get_code(ch, now);
      if (now != old) begin d = now - old; break; end
    end
  endtask

  task automatic wait_ready(output bit ok);
    ok = 0;
    for (int i = 0; i < 200*DIV; i++) begin
      @(negedge clk);
      if (chr == 2'b11) begin ok = 1; break; end
    end
  endtask

  task automatic restart(input int s0, input int s1);
    @(negedge clk); start = 0; seed = {TW'(s1), TW'(s0)};
    repeat (2) @(negedge clk); start = 1;
  endtask

  task automatic t_reset;
    chk(oe == 2'b00, "R9", "oe after reset", oe, 0);
    chk(chr == 2'b00, "R7", "ready flags after reset", chr, 0);
    chk(rdy == 1'b0, "R8", "ready_o after reset", rdy, 0);
  endtask

  task automatic t_gate;
    ctl_en = 1; start = 0; seed = {TW'(77), TW'(123)};
    repeat (2) @(negedge clk);
    chk(oe == 2'b00, "R9", "oe with start inactive", oe, 0);
    chk(c0 == 123, "R9", "code follows seed", c0, 123);
    start_pol = 0;
    repeat (2) @(negedge clk);
    chk(oe == 2'b11, "R9", "oe with active-low start", oe, 3);
    start_pol = 1; start = 1;
  endtask

  task automatic t_dir;
    int d, g;
    fast_en = 0; f0 = 16'd1000; f1 = 16'd3000;
    restart(300, 300);
    next_delta(0, d, g);
    chk(d == 1, "R4", "ch0 normal below target", d, 1);
    next_delta(0, d, g);
    chk(g == DIV, "R1", "cycles between steps", g, DIV);
    next_delta(1, d, g);
    chk(d == 1, "R4", "ch1 inverse above target", d, 1);
    @(negedge clk); f0 = 16'd2000; f1 = 16'd2000;
    next_delta(0, d, g);
    chk(d == -1, "R4", "ch0 normal above target", d, -1);
    next_delta(1, d, g);
    chk(d == -1, "R4", "ch1 inverse below target", d, -1);
  endtask

  task automatic t_fast;
    int d, g;
    fast_en = 1; f0 = 16'd1000;
    next_delta(0, d, g);
    chk(d == 8, "R5", "fast step large error", d, 8);
    f0 = 16'd1495;
    next_delta(0, d, g);
    chk(d == 1, "R5", "fast mode small error", d, 1);
    f0 = 16'd1491;
    next_delta(0, d, g);
    chk(d == 8, "R5", "fast mode error 9", d, 8);
  endtask

  task automatic t_sat;
    f0 = 16'd1000; f1 = 16'd2000; fast_en = 1;
    restart(1023, 0);
    repeat (4*DIV) @(negedge clk);
    chk(c0 == 1023, "R6", "saturate at full scale", c0, 1023);
    chk(c1 == 0, "R6", "saturate at zero", c1, 0);
  endtask

  task automatic t_converge;
    bit ok;
    fast_en = 0; plant_on = 1;
    restart(480, 520);
    wait_ready(ok);
    chk(ok, "R7", "ready after convergence", chr, 3);
    chk(sample[15:0] >= 1498 && sample[15:0] <= 1502, "R2", "ch0 at nominal", sample[15:0], 1500);
    chk(sample[31:16] >= 2498 && sample[31:16] <= 2502, "R2", "ch1 at nominal", sample[31:16], 2500);
    chk(rdy == 1'b1, "R8", "combined ready high", rdy, 1);
  endtask

  task automatic t_two_samples;
    bit ok;
    issue(2'b11, 4'b0000);
    chk(chr == 2'b00, "R7", "command clears ready next cycle", chr, 0);
    repeat (DIV-1) @(negedge clk);
    chk(chr == 2'b00, "R7", "one in-band sample not enough", chr, 0);
    wait_ready(ok);
    chk(ok, "R7", "ready after two in-band samples", chr, 3);
  endtask

  task automatic t_margin;
    bit ok;
    fast_en = 1;
    issue(2'b11, {2'b10, 2'b01});
    wait_ready(ok);
    chk(ok && sample[15:0] >= 1598 && sample[15:0] <= 1602, "R10", "ch0 margin-high setpoint", sample[15:0], 1600);
    chk(ok && sample[31:16] >= 2398 && sample[31:16] <= 2402, "R2", "ch1 margin-low", sample[31:16], 2400);
    issue(2'b11, 4'b1111);
    wait_ready(ok);
    chk(ok && sample[15:0] >= 1498 && sample[15:0] <= 1502, "R2", "code 11 selects nominal", sample[15:0], 1500);
  endtask

  task automatic t_ignore;
    bit ok;
    @(negedge clk); ctl_en = 0; seed = {TW'(520), TW'(480)};
    issue(2'b11, {2'b01, 2'b01});
    chk(oe == 2'b00, "R9", "released while disabled", oe, 0);
    @(negedge clk); ctl_en = 1;
    wait_ready(ok);
    chk(ok && sample[15:0] >= 1498 && sample[15:0] <= 1502, "R3", "command ignored when disabled", sample[15:0], 1500);
  endtask

  task automatic t_ready_pol;
    @(negedge clk); ready_pol = 0;
    #1 chk(rdy == 1'b0, "R8", "active-low ready with both ready", rdy, 0);
    issue(2'b01, 4'b0000);
    chk(rdy == 1'b1, "R8", "active-low ready inactive after command", rdy, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    wr_sp(0, 0, 1500); wr_sp(0, 1, 1600); wr_sp(0, 2, 1400);
    wr_sp(1, 0, 2500); wr_sp(1, 1, 2600); wr_sp(1, 2, 2400);
    t_gate;
    t_dir;
    t_fast;
    t_sat;
    t_converge;
    t_two_samples;
    t_margin;
    t_ignore;
    t_ready_pol;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8*150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule